// File: doc/BRIEF.md
# Mixed-Aspect Dual-Port Parity RAM

This block is a two-port synchronous memory with 16,384 data bits and 2,048 parity bits, all in one shared array. Each port has its own data width, set at elaboration to 1, 2, 4, 8, 16 or 32 bits. The address width and the depth of each port follow from that width. Ports that are 8 bits wide or wider also carry one parity bit for each byte.

The two ports see the same storage through different geometries. A 32-bit word written on one port can be read back as bytes, nibbles or single bits on the other port, with the least significant piece at the lowest narrow address. Parity bits are tied to byte positions in the shared space, so a byte-wide port and a word-wide port see the same parity bit for the same byte.

Each port has an enable, a write enable, an address, data and parity inputs, and registered data and parity outputs. A write also returns the newly written value on that port's own output (write-first). Both ports run on one shared clock and are otherwise fully independent.

Top module: `dual_aspect_ram`

## Requirements
- R1: A port of data width W has an address of 14 - log2(W) bits and 2^(14 - log2(W)) locations. The highest address reaches the last W bits of the 16,384-bit space. A width outside {1, 2, 4, 8, 16, 32} stops elaboration with an error.
- R2: On a rising clock edge with both enable and write enable high, the data input is stored at the addressed location.
- R3: On a rising clock edge with enable high and write enable low, the stored word at the address (and its parity) appears on the port outputs after that edge. The read latency is one cycle.
- R4: On a write edge, the port's data output shows the written data from that edge on (write-first).
- R5: While enable is low, nothing is written, and the data and parity outputs keep their values, whatever write enable, address and data do.
- R6: Word a of a W-bit port covers bits a*W through a*W+W-1 of the shared data space. Within a word, the lower bits map to the lower positions.
- R7: A port with W >= 8 has W/8 parity bits. Parity bit j of word a belongs to byte a*W/8 + j of the shared space. It is stored and read back together with its data, and it is shared between the ports by byte index.
- R8: A port with W < 8 has a one-bit parity input that is ignored and a one-bit parity output that always reads 0.
- R9: A synchronous active-high reset clears both ports' data and parity outputs to 0 on the next edge. It leaves the memory contents unchanged.
- R10: Writes on both ports on the same edge to disjoint bits both take effect, even when the bits lie in the same internal row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 14-log2(A_W) | Port A word address |
| a_din | input | A_W | Port A write data |
| a_pin | input | max(A_W/8,1) | Port A write parity |
| a_dout | output | A_W | Port A registered data output |
| a_pout | output | max(A_W/8,1) | Port A registered parity output |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 14-log2(B_W) | Port B word address |
| b_din | input | B_W | Port B write data |
| b_pin | input | max(B_W/8,1) | Port B write parity |
| b_dout | output | B_W | Port B registered data output |
| b_pout | output | max(B_W/8,1) | Port B registered parity output |

## Verification
Every result of this block is due one edge after its stimulus: read data, write-first data, the held value and the reset value are all captured by the output register on the edge that samples the request. Contents stored by a write are visible to a read issued on the next edge, so they appear two edges after the write. The bench drives each request on a falling edge and lets exactly one rising edge pass. It compares the outputs on the following falling edge, before it drives the next request. Cross-width checks write on one port and read on the other in a later cycle, so no check depends on a same-edge read of a cell that is being written.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int SPACE_BITS = 16384;
    localparam int ROW_DW     = 32;
    localparam int ROW_PW     = ROW_DW / 8;
    localparam int ROWS       = SPACE_BITS / ROW_DW;
    localparam int ROW_AW     = $clog2(ROWS);
    localparam int OFF_W      = $clog2(ROW_DW);
    localparam int POFF_W     = $clog2(ROW_PW);

    typedef logic [ROW_DW-1:0] row_data_t;
    typedef logic [ROW_PW-1:0] row_par_t;
    typedef logic [ROW_AW-1:0] row_idx_t;

    // one port's contribution to a row: which bits it owns and their new values
    typedef struct packed {
        row_idx_t  row;
        row_data_t dmask;
        row_data_t dval;
        row_par_t  pmask;
        row_par_t  pval;
    } row_upd_t;

    function automatic bit width_ok(int w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16) || (w == 32);
    endfunction

    function automatic int addr_w(int w);
        return $clog2(SPACE_BITS) - $clog2(w);
    endfunction

    function automatic bit has_par(int w);
        return w >= 8;
    endfunction

    function automatic int par_w(int w);
        return (w >= 8) ? w / 8 : 1;
    endfunction

    function automatic row_data_t merge_data(row_data_t old, row_upd_t u);
        return (old & ~u.dmask) | (u.dval & u.dmask);
    endfunction

    function automatic row_par_t merge_par(row_par_t old, row_upd_t u);
        return (old & ~u.pmask) | (u.pval & u.pmask);
    endfunction

endpackage

// File: rtl/dpr_port_map.sv
module dpr_port_map
    import dpr_pkg::*;
#(
    parameter int W = 8,
    localparam int AW    = addr_w(W),
    localparam int PW    = par_w(W),
    localparam int SLOTS = ROW_DW / W,
    localparam int SB    = $clog2(SLOTS)
) (
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  din,
    input  logic [PW-1:0] pin,
    input  row_data_t     rd_d,
    input  row_par_t      rd_p,
    output row_upd_t      upd,
    output logic [W-1:0]  rd_word,
    output logic [PW-1:0] rd_par
);

    logic [OFF_W-1:0]  off;
    logic [POFF_W-1:0] poff;
    row_idx_t          row;
    row_data_t         dmask;
    row_data_t         dval;
    row_par_t          pmask;
    row_par_t          pval;

    // slot within a row selects the bit offset; the upper address bits pick the row
    generate
        if (SB == 0) begin : g_full_row
            assign off = '0;
        end else begin : g_sub_row
            assign off = OFF_W'(addr[SB-1:0]) * OFF_W'(W);
        end
    endgenerate

    assign row   = ROW_AW'(addr >> SB);
    assign poff  = POFF_W'(off >> 3);
    assign dmask = row_data_t'({W{1'b1}}) << off;
    assign dval  = row_data_t'(din) << off;

    generate
        if (has_par(W)) begin : g_par
            assign pmask  = row_par_t'({PW{1'b1}}) << poff;
            assign pval   = row_par_t'(pin) << poff;
            assign rd_par = PW'(rd_p >> poff);
        end else begin : g_no_par
            logic unused_par;
            assign unused_par = ^pin ^ ^rd_p ^ ^poff;
            assign pmask  = '0;
            assign pval   = '0;
            assign rd_par = '0;
        end
    endgenerate

    assign rd_word = W'(rd_d >> off);
    assign upd     = '{row: row, dmask: dmask, dval: dval, pmask: pmask, pval: pval};

endmodule

// File: rtl/dpr_port_reg.sv
module dpr_port_reg #(
    parameter int W       = 8,
    parameter int PW      = 1,
    parameter bit HAS_PAR = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [W-1:0]  din,
    input  logic [PW-1:0] pin,
    input  logic [W-1:0]  rd_word,
    input  logic [PW-1:0] rd_par,
    output logic [W-1:0]  dout,
    output logic [PW-1:0] pout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            pout <= '0;
        end else if (en) begin
            if (we) begin
                dout <= din;
                pout <= HAS_PAR ? pin : '0;
            end else begin
                dout <= rd_word;
                pout <= rd_par;
            end
        end
    end

endmodule

// File: rtl/dual_aspect_ram.sv
module dual_aspect_ram
    import dpr_pkg::*;
#(
    parameter int A_W = 32,
    parameter int B_W = 8,
    localparam int A_AW = addr_w(A_W),
    localparam int B_AW = addr_w(B_W),
    localparam int A_PW = par_w(A_W),
    localparam int B_PW = par_w(B_W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            a_en,
    input  logic            a_we,
    input  logic [A_AW-1:0] a_addr,
    input  logic [A_W-1:0]  a_din,
    input  logic [A_PW-1:0] a_pin,
    output logic [A_W-1:0]  a_dout,
    output logic [A_PW-1:0] a_pout,
    input  logic            b_en,
    input  logic            b_we,
    input  logic [B_AW-1:0] b_addr,
    input  logic [B_W-1:0]  b_din,
    input  logic [B_PW-1:0] b_pin,
    output logic [B_W-1:0]  b_dout,
    output logic [B_PW-1:0] b_pout
);

    generate
        if (!width_ok(A_W)) begin : g_bad_a_width
            $error("dual_aspect_ram: port A width %0d is not 1, 2, 4, 8, 16 or 32", A_W);
        end
        if (!width_ok(B_W)) begin : g_bad_b_width
            $error("dual_aspect_ram: port B width %0d is not 1, 2, 4, 8, 16 or 32", B_W);
        end
    endgenerate

    row_data_t mem_d [ROWS];
    row_par_t  mem_p [ROWS];

    row_upd_t        upd_a, upd_b;
    row_data_t       rd_d_a, rd_d_b;
    row_par_t        rd_p_a, rd_p_b;
    logic [A_W-1:0]  word_a;
    logic [B_W-1:0]  word_b;
    logic [A_PW-1:0] par_a;
    logic [B_PW-1:0] par_b;
    logic            wr_a, wr_b, same_row;
    row_data_t       new_d_a, base_d_b, new_d_b;
    row_par_t        new_p_a, base_p_b, new_p_b;

    dpr_port_map #(.W(A_W)) u_map_a (
        .addr(a_addr), .din(a_din), .pin(a_pin),
        .rd_d(rd_d_a), .rd_p(rd_p_a),
        .upd(upd_a), .rd_word(word_a), .rd_par(par_a)
    );

    dpr_port_map #(.W(B_W)) u_map_b (
        .addr(b_addr), .din(b_din), .pin(b_pin),
        .rd_d(rd_d_b), .rd_p(rd_p_b),
        .upd(upd_b), .rd_word(word_b), .rd_par(par_b)
    );

    assign rd_d_a   = mem_d[upd_a.row];
    assign rd_p_a   = mem_p[upd_a.row];
    assign rd_d_b   = mem_d[upd_b.row];
    assign rd_p_b   = mem_p[upd_b.row];
    assign wr_a     = a_en && a_we;
    assign wr_b     = b_en && b_we;
    assign same_row = wr_a && (upd_a.row == upd_b.row);

    // port B merges on top of port A's result when both touch one row
    always_comb begin
        new_d_a  = merge_data(rd_d_a, upd_a);
        new_p_a  = merge_par(rd_p_a, upd_a);
        base_d_b = same_row ? new_d_a : rd_d_b;
        base_p_b = same_row ? new_p_a : rd_p_b;
        new_d_b  = merge_data(base_d_b, upd_b);
        new_p_b  = merge_par(base_p_b, upd_b);
    end

    always_ff @(posedge clk) begin
        if (wr_a) begin
            mem_d[upd_a.row] <= new_d_a;
            mem_p[upd_a.row] <= new_p_a;
        end
        if (wr_b) begin
            mem_d[upd_b.row] <= new_d_b;
            mem_p[upd_b.row] <= new_p_b;
        end
    end

    dpr_port_reg #(.W(A_W), .PW(A_PW), .HAS_PAR(has_par(A_W))) u_out_a (
        .clk(clk), .rst(rst), .en(a_en), .we(a_we),
        .din(a_din), .pin(a_pin), .rd_word(word_a), .rd_par(par_a),
        .dout(a_dout), .pout(a_pout)
    );

    dpr_port_reg #(.W(B_W), .PW(B_PW), .HAS_PAR(has_par(B_W))) u_out_b (
        .clk(clk), .rst(rst), .en(b_en), .we(b_we),
        .din(b_din), .pin(b_pin), .rd_word(word_b), .rd_par(par_b),
        .dout(b_dout), .pout(b_pout)
    );

endmodule

// File: rtl/dual_aspect_ram_checker.sv
module dual_aspect_ram_checker
    import dpr_pkg::*;
#(
    parameter int A_W = 32,
    parameter int B_W = 8,
    localparam int A_PW = par_w(A_W),
    localparam int B_PW = par_w(B_W)
) (
    input logic            clk,
    input logic            rst,
    input logic            a_en,
    input logic            a_we,
    input logic [A_W-1:0]  a_din,
    input logic [A_PW-1:0] a_pin,
    input logic [A_W-1:0]  a_dout,
    input logic [A_PW-1:0] a_pout,
    input logic            b_en,
    input logic            b_we,
    input logic [B_W-1:0]  b_din,
    input logic [B_PW-1:0] b_pin,
    input logic [B_W-1:0]  b_dout,
    input logic [B_PW-1:0] b_pout
);

    p_reset_clears_r9: assert property (@(posedge clk)
        rst |=> (a_dout == '0) && (a_pout == '0) && (b_dout == '0) && (b_pout == '0));

    p_write_first_a_r4: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we) |=> (a_dout == $past(a_din)));

    p_write_first_b_r4: assert property (@(posedge clk) disable iff (rst)
        (b_en && b_we) |=> (b_dout == $past(b_din)));

    p_idle_hold_a_r5: assert property (@(posedge clk) disable iff (rst)
        !a_en |=> ($stable(a_dout) && $stable(a_pout)));

    p_idle_hold_b_r5: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> ($stable(b_dout) && $stable(b_pout)));

    generate
        if (has_par(A_W)) begin : g_par_a
            p_parity_wf_a_r7: assert property (@(posedge clk) disable iff (rst)
                (a_en && a_we) |=> (a_pout == $past(a_pin)));
        end else begin : g_npar_a
            p_parity_zero_a_r8: assert property (@(posedge clk) disable iff (rst)
                (a_en && a_we) |=> (a_pout == '0));
        end
        if (has_par(B_W)) begin : g_par_b
            p_parity_wf_b_r7: assert property (@(posedge clk) disable iff (rst)
                (b_en && b_we) |=> (b_pout == $past(b_pin)));
        end else begin : g_npar_b
            p_parity_zero_b_r8: assert property (@(posedge clk) disable iff (rst)
                (b_en && b_we) |=> (b_pout == '0));
        end
    endgenerate

endmodule

bind dual_aspect_ram dual_aspect_ram_checker #(.A_W(A_W), .B_W(B_W)) u_chk (.*);

// File: tb/dual_aspect_ram_test.sv
module dual_aspect_ram_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // uut: port A 32+4 bits (9-bit address), port B 8+1 bits (11-bit address)
    logic        a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [8:0]  a_addr = '0;
    logic [31:0] a_din = '0, a_dout;
    logic [3:0]  a_pin = '0, a_pout;
    logic [10:0] b_addr = '0;
    logic [7:0]  b_din = '0, b_dout;
    logic [0:0]  b_pin = '0, b_pout;

    // uut2: port C 16+2 bits (10-bit address), port D 1 bit (14-bit address)
    logic        c_en = 0, c_we = 0, d_en = 0, d_we = 0;
    logic [9:0]  c_addr = '0;
    logic [15:0] c_din = '0, c_dout;
    logic [1:0]  c_pin = '0, c_pout;
    logic [13:0] d_addr = '0;
    logic [0:0]  d_din = '0, d_dout;
    logic [0:0]  d_pin = '0, d_pout;

    dual_aspect_ram #(.A_W(32), .B_W(8)) uut (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(a_dout), .a_pout(a_pout),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(b_dout), .b_pout(b_pout)
    );

    dual_aspect_ram #(.A_W(16), .B_W(1)) uut2 (
        .clk(clk), .rst(rst),
        .a_en(c_en), .a_we(c_we), .a_addr(c_addr), .a_din(c_din), .a_pin(c_pin),
        .a_dout(c_dout), .a_pout(c_pout),
        .b_en(d_en), .b_we(d_we), .b_addr(d_addr), .b_din(d_din), .b_pin(d_pin),
        .b_dout(d_dout), .b_pout(d_pout)
    );

    typedef struct packed {
        logic        port_b;
        logic        we;
        logic [13:0] addr;
        logic [31:0] data;
        logic [3:0]  par;
        logic [31:0] exp_d;
        logic [3:0]  exp_p;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 14'd5,    32'hA1B2C3D4, 4'hA, 32'hA1B2C3D4, 4'hA}, // R4 R7 write-first
        '{1'b0, 1'b0, 14'd5,    32'h0,        4'h0, 32'hA1B2C3D4, 4'hA}, // R2 R3 read back
        '{1'b1, 1'b0, 14'd20,   32'h0,        4'h0, 32'h000000D4, 4'h0}, // R6 R7 byte 0
        '{1'b1, 1'b0, 14'd21,   32'h0,        4'h0, 32'h000000C3, 4'h1}, // R6 R7 byte 1
        '{1'b1, 1'b0, 14'd22,   32'h0,        4'h0, 32'h000000B2, 4'h0}, // R6 R7 byte 2
        '{1'b1, 1'b0, 14'd23,   32'h0,        4'h0, 32'h000000A1, 4'h1}, // R6 R7 byte 3
        '{1'b1, 1'b1, 14'd22,   32'h5E,       4'h1, 32'h0000005E, 4'h1}, // R2 R4 narrow write
        '{1'b0, 1'b0, 14'd5,    32'h0,        4'h0, 32'hA15EC3D4, 4'hE}, // R6 R7 merged view
        '{1'b0, 1'b1, 14'd511,  32'h11223344, 4'h0, 32'h11223344, 4'h0}, // R1 top word
        '{1'b1, 1'b1, 14'd2047, 32'hFF,       4'h1, 32'h000000FF, 4'h1}, // R1 top byte
        '{1'b0, 1'b0, 14'd511,  32'h0,        4'h0, 32'hFF223344, 4'h8}, // R1 R6 R7
        '{1'b0, 1'b1, 14'd0,    32'h01020304, 4'h1, 32'h01020304, 4'h1}, // R4 address 0
        '{1'b1, 1'b0, 14'd0,    32'h0,        4'h0, 32'h00000004, 4'h1}  // R3 R6 byte 0
    };

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one rising edge, then return on the following falling edge with enables dropped
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        a_en = 0; a_we = 0; b_en = 0; b_we = 0;
        c_en = 0; c_we = 0; d_en = 0; d_we = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R9 reset state
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R9 reset a_dout", a_dout, 32'h0);
        check("R9 reset b_dout", 32'(b_dout), 32'h0);
        check("R9 reset c_dout", 32'(c_dout), 32'h0);

        // table walk: R2 R3 R4 R6 R7 R1
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VEC[i];
            if (!v.port_b) begin
                a_en = 1; a_we = v.we; a_addr = v.addr[8:0]; a_din = v.data; a_pin = v.par;
            end else begin
                b_en = 1; b_we = v.we; b_addr = v.addr[10:0]; b_din = v.data[7:0]; b_pin = v.par[0:0];
            end
            step();
            if (!v.port_b) begin
                check($sformatf("R3/R4 table %0d data", i), a_dout, v.exp_d);
                check($sformatf("R7 table %0d parity", i), 32'(a_pout), 32'(v.exp_p));
            end else begin
                check($sformatf("R3/R4/R6 table %0d data", i), 32'(b_dout), v.exp_d);
                check($sformatf("R7 table %0d parity", i), 32'(b_pout), 32'(v.exp_p));
            end
        end

        // R5: disabled write does nothing, outputs hold
        a_en = 0; a_we = 1; a_addr = 9'd5; a_din = 32'h0; a_pin = 4'h0;
        b_en = 0; b_we = 1; b_addr = 11'd20; b_din = 8'h00; b_pin = 1'b0;
        step();
        check("R5 hold a_dout", a_dout, 32'h01020304);
        check("R5 hold a_pout", 32'(a_pout), 32'h1);
        check("R5 hold b_dout", 32'(b_dout), 32'h04);
        a_en = 1; a_addr = 9'd5;
        step();
        check("R5 no write at word 5", a_dout, 32'hA15EC3D4);

        // R9: mid-run reset clears outputs, keeps memory
        rst = 1;
        step();
        rst = 0;
        check("R9 mid reset a_dout", a_dout, 32'h0);
        check("R9 mid reset a_pout", 32'(a_pout), 32'h0);
        a_en = 1; a_addr = 9'd5;
        step();
        check("R9 memory kept", a_dout, 32'hA15EC3D4);

        // uut2: prepare known contents
        c_en = 1; c_we = 1; c_addr = 10'd1; c_din = 16'h0; c_pin = 2'b00;
        step();
        c_en = 1; c_we = 1; c_addr = 10'd1023; c_din = 16'h0; c_pin = 2'b00;
        step();
        // R10: same edge, same row, disjoint bits
        c_en = 1; c_we = 1; c_addr = 10'd0; c_din = 16'hFFFF; c_pin = 2'b11;
        d_en = 1; d_we = 1; d_addr = 14'd20; d_din = 1'b1; d_pin = 1'b1;
        step();
        check("R4 write-first d_dout", 32'(d_dout), 32'h1);
        check("R8 narrow parity zero", 32'(d_pout), 32'h0);
        check("R7 write-first c_pout", 32'(c_pout), 32'h3);
        d_en = 1; d_addr = 14'd20;
        step();
        check("R10 bit 20 kept", 32'(d_dout), 32'h1);
        c_en = 1; c_addr = 10'd1;
        step();
        check("R10 R6 word 1 view", 32'(c_dout), 32'h0010);
        check("R7 word 1 parity", 32'(c_pout), 32'h0);
        d_en = 1; d_addr = 14'd3;
        step();
        check("R6 bit 3 from 16-bit word", 32'(d_dout), 32'h1);
        d_en = 1; d_addr = 14'd17;
        step();
        check("R6 bit 17 clear", 32'(d_dout), 32'h0);
        // R1: last single-bit address maps to the top bit of the last 16-bit word
        d_en = 1; d_we = 1; d_addr = 14'd16383; d_din = 1'b1; d_pin = 1'b1;
        step();
        check("R8 parity zero after write", 32'(d_pout), 32'h0);
        c_en = 1; c_addr = 10'd1023;
        step();
        check("R1 R6 top bit", 32'(c_dout), 32'h8000);

        finish_run();
    end

endmodule